// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block services a circular ring of transmit descriptors kept in system memory. A kick strobe starts a walk. For each descriptor it reads two 32-bit words over a plain request/acknowledge memory port. It then copies the referenced buffer bytes, one byte per request, into a local frame store. It writes the descriptor's second word back with its ownership and status bits cleared, and moves its ring pointers forward. A frame may be split over several descriptors. When the descriptor carrying the end-of-packet flag has been consumed, the gathered frame leaves on a byte stream with a valid/ready handshake, and the final byte is marked.

The ring is described by a base address and an entry-count field. The walker keeps a current pointer and a next pointer. Before each fetch it checks the next pointer against the ring bounds and falls back to the base if that pointer is out of range. The walker signals when it is idle, pulses a done strobe when a walk has sent a frame, and pulses an error strobe when a fragment would not fit in the frame store.

Top module: `txRingWalker`

## Requirements
- R1: A kick is accepted only while `txStart` is 1, `dmaDisable` is 0 and `linkUp` is 1. Otherwise the kick leaves pointers, idle, stream and memory port untouched.
- R2: A descriptor is 8 bytes, little-endian, fetched as two word reads. The word at the current pointer is the buffer address. The word at pointer+4 holds the length field in bits 15:0 and the flags in bits 31:16. The walker copies length+1 bytes, starting at the buffer address.
- R3: Before each fetch, the current pointer takes the next pointer's value. It takes the base instead when the next pointer is below the base, or when next+8 exceeds base+8*(ringCntM1+1).
- R4: After a descriptor is consumed, the next pointer becomes current+8. It wraps to the base when that value is at or beyond the ring end.
- R5: A walk stops at the first descriptor whose valid flag (flags bit 15) is 0, without writing that descriptor back. It also stops right after a descriptor whose last flag (flags bit 0) is 1. It never consumes more than ringCntM1+1 descriptors.
- R6: Write-back rewrites the word at pointer+4. The length is kept, the valid bit and the status bits 14:9 are cleared, and every other flag bit is kept.
- R7: Fragment bytes are concatenated in ring order, including across kicks. On the last flag the whole frame is sent, with `outLast` on its final byte, and the fill count returns to zero.
- R8: `idle` is 1 after reset and whenever no walk is running. It is 0 from the cycle after an accepted kick until the walk ends.
- R9: `txDone` pulses for one cycle at the end of a walk only if that walk sent a frame.
- R10: If the fill count plus length+1 exceeds the frame store size (64 bytes), `fragErr` pulses and the partial frame is discarded. The walk ends, and that descriptor is neither written back nor passed by the next pointer.
- R11: A `ringReset` pulse while idle loads both pointers from the base and clears the fill count.
- R12: While `outValid` is 1 and `outReady` is 0, the stream output holds its data and last marker. While a memory request waits for `memAck`, its address and direction hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Start-walk strobe |
| ringReset | input | 1 | Reload pointers from base, drop partial frame |
| txStart | input | 1 | Transmitter started |
| dmaDisable | input | 1 | DMA disabled |
| linkUp | input | 1 | Link is up |
| ringBase | input | 32 | Ring base address |
| ringCntM1 | input | 4 | Ring entry count minus one |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completed, read data valid |
| memRdata | input | 32 | Read data (byte reads use bits 7:0) |
| outValid | output | 1 | Stream byte valid |
| outData | output | 8 | Stream byte |
| outLast | output | 1 | Final byte of frame |
| outReady | input | 1 | Stream sink ready |
| curPtr | output | 32 | Current descriptor pointer |
| nextPtr | output | 32 | Next descriptor pointer |
| idle | output | 1 | No walk running |
| txDone | output | 1 | Walk ended having sent a frame |
| fragErr | output | 1 | Fragment overflowed the frame store |

## Verification
The bench goes after several corner cases, each tied to a specific failure:
- Next pointer left outside the ring after the count or base changes. A walker that skipped the range check would fetch from the stale address.
- Walks that fill the whole ring without a last flag. A walker with a wrong bound would loop forever or stop early.
- Frames that straddle two kicks. A walker that reset the fill count on each kick would lose the first fragments.
- Overflowing fragment. A walker that wrote the descriptor back, or advanced past it, would leave the ring out of step with the software's view of ownership.
- Descriptors carrying set status bits. These expose a write-back mask that is too wide or too narrow.
- A sink that stalls at random. This catches output data that changes before it is accepted.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_RD0, S_RD1, S_EVAL, S_COPY, S_WB, S_ADV, S_SEND, S_DONE
  } walkState_t;

  typedef enum logic [1:0] {A_DESC0, A_DESC1, A_BUF} addrSel_t;

  typedef struct packed {
    logic     selCur;
    logic     lat0;
    logic     lat1;
    logic     startFrag;
    logic     storeByte;
    logic     commitFrag;
    logic     advance;
    logic     dropFill;
    logic     resetRing;
    logic     clrWalk;
    logic     clrSend;
    logic     stepSend;
    addrSel_t aSel;
  } dpStrobe_t;

endpackage

// File: rtl/txwCtrl.sv
module txwCtrl
  import txw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kick,
  input  logic      ringReset,
  input  logic      txStart,
  input  logic      dmaDisable,
  input  logic      linkUp,
  input  logic      memAck,
  input  logic      outReady,
  input  logic      descValid,
  input  logic      descLast,
  input  logic      overflow,
  input  logic      fragEnd,
  input  logic      walkLast,
  input  logic      sendLast,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      outValid,
  output logic      idle,
  output logic      txDone,
  output logic      fragErr
);

  walkState_t st, nst;
  logic sentQ;
  logic go;

  assign go = txStart && !dmaDisable && linkUp;

  always_comb begin
    nst      = st;
    stb      = '0;
    stb.aSel = A_DESC0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    outValid = 1'b0;
    case (st)
      S_IDLE: begin
        if (kick && go) begin
          stb.clrWalk = 1'b1;
          nst = S_SEL;
        end else if (ringReset) begin
          stb.resetRing = 1'b1;
        end
      end
      S_SEL: begin
        stb.selCur = 1'b1;
        nst = S_RD0;
      end
      S_RD0: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.lat0 = 1'b1;
          nst = S_RD1;
        end
      end
      S_RD1: begin
        memReq = 1'b1;
        stb.aSel = A_DESC1;
        if (memAck) begin
          stb.lat1 = 1'b1;
          nst = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!descValid) begin
          nst = S_DONE;
        end else if (overflow) begin
          stb.dropFill = 1'b1;
          nst = S_DONE;
        end else begin
          stb.startFrag = 1'b1;
          nst = S_COPY;
        end
      end
      S_COPY: begin
        memReq = 1'b1;
        stb.aSel = A_BUF;
        if (memAck) begin
          stb.storeByte = 1'b1;
          if (fragEnd) begin
            stb.commitFrag = 1'b1;
            nst = S_WB;
          end
        end
      end
      S_WB: begin
        memReq = 1'b1;
        memWe = 1'b1;
        stb.aSel = A_DESC1;
        if (memAck) nst = S_ADV;
      end
      S_ADV: begin
        stb.advance = 1'b1;
        if (descLast) begin
          stb.clrSend = 1'b1;
          nst = S_SEND;
        end else if (walkLast) begin
          nst = S_DONE;
        end else begin
          nst = S_SEL;
        end
      end
      S_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          if (sendLast) begin
            stb.dropFill = 1'b1;
            nst = S_DONE;
          end else begin
            stb.stepSend = 1'b1;
          end
        end
      end
      S_DONE:  nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sentQ <= 1'b0;
    end else begin
      st <= nst;
      if (st == S_IDLE && kick && go) sentQ <= 1'b0;
      else if (st == S_SEND && outReady && sendLast) sentQ <= 1'b1;
    end
  end

  assign idle    = (st == S_IDLE);
  assign txDone  = (st == S_DONE) && sentQ;
  assign fragErr = (st == S_EVAL) && descValid && overflow;

  // R8
  kick_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && kick && go) |=> !idle);

  // R9
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txDone |=> (idle && !txDone));

  // R1
  gated_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && kick && !go) |=> idle);

endmodule

// File: rtl/txwData.sv
module txwData
  import txw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 4,
  parameter int BUF_BYTES = 64,
  parameter int VALID_BIT = 15,
  parameter int LAST_BIT  = 0,
  parameter logic [15:0] STAT_MASK = 16'h7E00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [CNT_W-1:0]  ringCntM1,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic [ADDR_W-1:0] curPtr,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              descValid,
  output logic              descLast,
  output logic              overflow,
  output logic              fragEnd,
  output logic              walkLast,
  output logic              sendLast
);

  localparam int LEN_W  = 16;
  localparam int FILL_W = $clog2(BUF_BYTES + 1);
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int EXT_W  = ADDR_W + 1;
  localparam int SUM_W  = LEN_W + 2;
  localparam logic [15:0] CLR_MASK = STAT_MASK | (16'h1 << VALID_BIT);

  logic [ADDR_W-1:0] curQ, nextQ, bufAddrQ, selPtr, advPtr;
  logic [LEN_W-1:0]  lenQ, byteIdx;
  logic [15:0]       flagsQ;
  logic [FILL_W-1:0] fillQ;
  logic [CNT_W-1:0]  walkCnt;
  logic [IDX_W-1:0]  sendIdx;
  logic [7:0]        fb [BUF_BYTES];

  logic [EXT_W-1:0] baseX, ringEnd, nextX, curX, stepNext;
  logic [SUM_W-1:0] need;
  logic [LEN_W:0]   wrIdx;

  always_comb begin
    baseX    = {1'b0, ringBase};
    ringEnd  = baseX + ((EXT_W'(ringCntM1) + EXT_W'(1)) << 3);
    nextX    = {1'b0, nextQ};
    curX     = {1'b0, curQ};
    selPtr   = ((nextX < baseX) || (nextX + EXT_W'(8) > ringEnd)) ? ringBase : nextQ;
    stepNext = curX + EXT_W'(8);
    advPtr   = (stepNext >= ringEnd) ? ringBase : stepNext[ADDR_W-1:0];
    need     = SUM_W'(fillQ) + SUM_W'(lenQ) + SUM_W'(1);
    wrIdx    = (LEN_W + 1)'(fillQ) + (LEN_W + 1)'(byteIdx);
  end

  always_comb begin
    case (stb.aSel)
      A_DESC0: memAddr = curQ;
      A_DESC1: memAddr = curQ + ADDR_W'(4);
      default: memAddr = bufAddrQ + ADDR_W'(byteIdx);
    endcase
  end

  assign memWdata  = {flagsQ & ~CLR_MASK, lenQ};
  assign descValid = flagsQ[VALID_BIT];
  assign descLast  = flagsQ[LAST_BIT];
  assign overflow  = need > SUM_W'(BUF_BYTES);
  assign fragEnd   = (byteIdx == lenQ);
  assign walkLast  = (walkCnt == ringCntM1);
  assign sendLast  = (FILL_W'(sendIdx) == fillQ - FILL_W'(1));
  assign outData   = fb[sendIdx];
  assign outLast   = sendLast;
  assign curPtr    = curQ;
  assign nextPtr   = nextQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curQ     <= '0;
      nextQ    <= '0;
      bufAddrQ <= '0;
      lenQ     <= '0;
      flagsQ   <= '0;
      byteIdx  <= '0;
      fillQ    <= '0;
      walkCnt  <= '0;
      sendIdx  <= '0;
    end else begin
      if (stb.resetRing) begin
        curQ  <= ringBase;
        nextQ <= ringBase;
        fillQ <= '0;
      end
      if (stb.selCur) curQ <= selPtr;
      if (stb.lat0) bufAddrQ <= memRdata[ADDR_W-1:0];
      if (stb.lat1) begin
        lenQ   <= memRdata[15:0];
        flagsQ <= memRdata[31:16];
      end
      if (stb.startFrag) byteIdx <= '0;
      else if (stb.storeByte) byteIdx <= byteIdx + LEN_W'(1);
      if (stb.commitFrag) fillQ <= fillQ + FILL_W'(lenQ) + FILL_W'(1);
      else if (stb.dropFill) fillQ <= '0;
      if (stb.clrWalk) walkCnt <= '0;
      else if (stb.advance) walkCnt <= walkCnt + CNT_W'(1);
      if (stb.advance) nextQ <= advPtr;
      if (stb.clrSend) sendIdx <= '0;
      else if (stb.stepSend) sendIdx <= sendIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) fb[wrIdx[IDX_W-1:0]] <= memRdata[7:0];
  end

  // R3
  cur_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.selCur |=> ((curX >= baseX) && (curX + EXT_W'(8) <= ringEnd)));

  // R4
  next_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.advance |=> ((nextX >= baseX) && (nextX < ringEnd)));

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commitFrag |=> (fillQ <= FILL_W'(BUF_BYTES)));

endmodule

// File: rtl/txRingWalker.sv
module txRingWalker
  import txw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 4,
  parameter int BUF_BYTES = 64,
  parameter int VALID_BIT = 15,
  parameter int LAST_BIT  = 0,
  parameter logic [15:0] STAT_MASK = 16'h7E00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              ringReset,
  input  logic              txStart,
  input  logic              dmaDisable,
  input  logic              linkUp,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [CNT_W-1:0]  ringCntM1,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              outLast,
  input  logic              outReady,
  output logic [ADDR_W-1:0] curPtr,
  output logic [ADDR_W-1:0] nextPtr,
  output logic              idle,
  output logic              txDone,
  output logic              fragErr
);

  dpStrobe_t stb;
  logic descValid, descLast, overflow, fragEnd, walkLast, sendLast;

  txwCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ringReset(ringReset),
    .txStart(txStart), .dmaDisable(dmaDisable), .linkUp(linkUp),
    .memAck(memAck), .outReady(outReady), .descValid(descValid),
    .descLast(descLast), .overflow(overflow), .fragEnd(fragEnd),
    .walkLast(walkLast), .sendLast(sendLast), .stb(stb), .memReq(memReq),
    .memWe(memWe), .outValid(outValid), .idle(idle), .txDone(txDone),
    .fragErr(fragErr)
  );

  txwData #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES),
    .VALID_BIT(VALID_BIT), .LAST_BIT(LAST_BIT), .STAT_MASK(STAT_MASK)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .ringBase(ringBase),
    .ringCntM1(ringCntM1), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .outData(outData), .outLast(outLast),
    .curPtr(curPtr), .nextPtr(nextPtr), .descValid(descValid),
    .descLast(descLast), .overflow(overflow), .fragEnd(fragEnd),
    .walkLast(walkLast), .sendLast(sendLast)
  );

  // R12
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

// File: tb/tb_txRingWalker.sv
`timescale 1ns/1ps
module tb_txRingWalker;

  localparam int BUFB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0, ringReset = 1'b0;
  logic        txStart = 1'b1, dmaDisable = 1'b0, linkUp = 1'b1;
  logic [31:0] ringBase = 32'h100;
  logic [3:0]  ringCntM1 = 4'd3;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        outValid, outLast, outReady;
  logic [7:0]  outData;
  logic [31:0] curPtr, nextPtr;
  logic        idle, txDone, fragErr;

  txRingWalker dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ringReset(ringReset),
    .txStart(txStart), .dmaDisable(dmaDisable), .linkUp(linkUp),
    .ringBase(ringBase), .ringCntM1(ringCntM1), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outReady(outReady), .curPtr(curPtr),
    .nextPtr(nextPtr), .idle(idle), .txDone(txDone), .fragErr(fragErr)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem    [4096];
  logic [7:0] refMem [4096];
  logic [11:0] ma;

  // memory responder and random sink
  always @(posedge clk) begin
    if (!rst_n) begin
      memAck   <= 1'b0;
      memRdata <= '0;
      outReady <= 1'b0;
    end else begin
      if (memReq && !memAck && ($urandom % 3 != 0)) begin
        ma = memAddr[11:0];
        memAck <= 1'b1;
        if (memWe) begin
          mem[ma]      <= memWdata[7:0];
          mem[ma + 1]  <= memWdata[15:8];
          mem[ma + 2]  <= memWdata[23:16];
          mem[ma + 3]  <= memWdata[31:24];
        end else begin
          memRdata <= {mem[ma + 3], mem[ma + 2], mem[ma + 1], mem[ma]};
        end
      end else begin
        memAck <= 1'b0;
      end
      outReady <= ($urandom % 4 != 0);
    end
  end

  logic [8:0] gotQ[$];
  logic [8:0] expQ[$];
  logic [7:0] mFrame[$];
  int doneCnt = 0, errCnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid && outReady) gotQ.push_back({outLast, outData});
      if (txDone) doneCnt++;
      if (fragErr) errCnt++;
    end
  end

  int unsigned mCur = 0, mNext = 0, mFill = 0;
  int expDone = 0, expErr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int unsigned a);
    return {refMem[(a + 3) & 12'hfff], refMem[(a + 2) & 12'hfff],
            refMem[(a + 1) & 12'hfff], refMem[a & 12'hfff]};
  endfunction

  task automatic putByte(input int unsigned a, input logic [7:0] v);
    mem[a & 12'hfff] = v;
    refMem[a & 12'hfff] = v;
  endtask

  task automatic putDesc(input int idx, input int lenM1, input logic [15:0] fl);
    int unsigned da, ba;
    da = ringBase + idx * 8;
    ba = 32'h400 + idx * 64;
    for (int k = 0; k < 4; k++) putByte(da + k, 8'(ba >> (8 * k)));
    putByte(da + 4, 8'(lenM1));
    putByte(da + 5, 8'(lenM1 >> 8));
    putByte(da + 6, fl[7:0]);
    putByte(da + 7, fl[15:8]);
    for (int k = 0; k < 64; k++) putByte(ba + k, 8'($urandom));
  endtask

  // reference walk computed from the requirements
  task automatic refKick();
    int unsigned cnt, endA, ba, len;
    logic [31:0] w1;
    logic [15:0] fl;
    if (!(txStart && !dmaDisable && linkUp)) return;
    cnt  = ringCntM1 + 1;
    endA = ringBase + cnt * 8;
    for (int i = 0; i < cnt; i++) begin
      if (mNext < ringBase || mNext + 8 > endA) mCur = ringBase;
      else mCur = mNext;
      ba = rd32(mCur);
      w1 = rd32(mCur + 4);
      len = w1[15:0];
      fl  = w1[31:16];
      if (!fl[15]) break;
      if (mFill + len + 1 > BUFB) begin
        expErr++;
        mFill = 0;
        mFrame.delete();
        break;
      end
      for (int j = 0; j <= len; j++) mFrame.push_back(refMem[(ba + j) & 12'hfff]);
      mFill += len + 1;
      refMem[(mCur + 6) & 12'hfff] = fl[7:0] & 8'h00;
      refMem[(mCur + 6) & 12'hfff] = fl[7:0];
      refMem[(mCur + 7) & 12'hfff] = fl[15:8] & 8'h01;
      mNext = (mCur + 8 >= endA) ? ringBase : mCur + 8;
      if (fl[0]) begin
        foreach (mFrame[k]) expQ.push_back({(k == mFrame.size() - 1), mFrame[k]});
        mFrame.delete();
        mFill = 0;
        expDone++;
        break;
      end
    end
  endtask

  task automatic doRingReset();
    @(negedge clk) ringReset = 1'b1;
    @(negedge clk) ringReset = 1'b0;
    mCur = ringBase;
    mNext = ringBase;
    mFill = 0;
    mFrame.delete();
  endtask

  task automatic doKick(input string tag);
    bit gate;
    int w;
    gate = txStart && !dmaDisable && linkUp;
    gotQ.delete();
    expQ.delete();
    refKick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    // R8 / R1: idle one cycle after the kick
    chk(idle == !gate, gate ? "R8" : "R1", {tag, " idle after kick"}, idle, !gate);
    w = 0;
    while (!(idle && !outValid) && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (2) @(negedge clk);
    chk(w < 5000, "R8", {tag, " walk ends"}, w, 0);
    // R7 / R2 frame contents and last marker
    chk(gotQ.size() == expQ.size(), "R7", {tag, " frame length"}, gotQ.size(), expQ.size());
    foreach (expQ[k])
      if (k < gotQ.size())
        chk(gotQ[k] == expQ[k], "R2 R7", {tag, " frame byte"}, gotQ[k], expQ[k]);
    // R3 R4 pointers
    chk(curPtr == mCur, "R3", {tag, " curPtr"}, curPtr, mCur);
    chk(nextPtr == mNext, "R4", {tag, " nextPtr"}, nextPtr, mNext);
    // R9 / R10 pulses
    chk(doneCnt == expDone, "R9", {tag, " txDone count"}, doneCnt, expDone);
    chk(errCnt == expErr, "R10", {tag, " fragErr count"}, errCnt, expErr);
    // R6 write-back image of descriptor area
    begin
      int bad = -1;
      for (int a = 0; a < 32'h400; a++) if (mem[a] !== refMem[a] && bad < 0) bad = a;
      chk(bad < 0, "R6", {tag, " descriptor memory"}, bad, -1);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'h00; refMem[a] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 R11 reset state
    chk(idle == 1'b1, "R8", "reset idle", idle, 1);
    chk(curPtr == 0 && nextPtr == 0, "R11", "reset pointers", curPtr, 0);
    chk(outValid == 1'b0 && txDone == 1'b0, "R9", "reset outputs", outValid, 0);

    // R11 ring reset
    ringBase = 32'h100; ringCntM1 = 4'd3;
    doRingReset();
    @(negedge clk);
    chk(curPtr == 32'h100 && nextPtr == 32'h100, "R11", "ring reset ptrs", nextPtr, 32'h100);

    // R1 gating
    putDesc(0, 9, 16'hFE01);
    txStart = 1'b0; doKick("gate start");
    txStart = 1'b1; dmaDisable = 1'b1; doKick("gate dma");
    dmaDisable = 1'b0; linkUp = 1'b0; doKick("gate link");
    linkUp = 1'b1;

    // R6 single frame with status bits set
    doKick("single");
    chk({mem[32'h107], mem[32'h106]} == 16'h0001, "R6", "flags after write-back",
        {mem[32'h107], mem[32'h106]}, 16'h0001);
    chk({mem[32'h105], mem[32'h104]} == 16'd9, "R6", "length kept",
        {mem[32'h105], mem[32'h104]}, 9);

    // R7 R4 multi-fragment ending at ring end (wraps)
    putDesc(1, 3, 16'h8000);
    putDesc(2, 4, 16'h8200);
    putDesc(3, 0, 16'h8001);
    doKick("multi frag wrap");

    // R5 invalid descriptor stops walk
    putDesc(0, 5, 16'h0001);
    doKick("invalid");

    // R5 whole ring without last, then R7 completion across kicks
    for (int i = 0; i < 4; i++) putDesc(i, 1, 16'h8000);
    doKick("ring limit");
    putDesc(0, 0, 16'h8001);
    doKick("across kicks");

    // R10 overflow
    putDesc(1, 31, 16'h8000);
    putDesc(2, 31, 16'h8000);
    putDesc(3, 31, 16'h8000);
    putDesc(0, 0, 16'h8000);
    doKick("overflow");
    putDesc(0, 0, 16'h8001);
    doKick("after overflow");

    // R3 snap when next lies past a shrunken ring, and below a moved base
    ringCntM1 = 4'd7;
    doRingReset();
    putDesc(0, 2, 16'h8000);
    putDesc(1, 2, 16'h8000);
    putDesc(2, 2, 16'h8001);
    doKick("snap setup");
    ringCntM1 = 4'd1;
    putDesc(0, 3, 16'h8001);
    doKick("snap past end");
    ringBase = 32'h180;
    doRingReset();
    ringBase = 32'h100;
    ringBase = 32'h1C0;
    putDesc(0, 2, 16'h8001);
    doKick("snap below base");

    // random mix
    for (int it = 0; it < 120; it++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) ringBase = 32'h100 + 32'h40 * ($urandom % 4);
      ringCntM1 = 4'($urandom % 8);
      if ($urandom % 10 == 0) doRingReset();
      txStart    = ($urandom % 12 != 0);
      dmaDisable = ($urandom % 12 == 0);
      linkUp     = ($urandom % 12 != 0);
      for (int i = 0; i <= ringCntM1; i++) begin
        logic [15:0] fl;
        fl = 16'($urandom) & 16'h7E00;
        if ($urandom % 8 != 0) fl[15] = 1'b1;
        if ($urandom % 3 == 0) fl[0] = 1'b1;
        putDesc(i, $urandom % 16, fl);
      end
      doKick("random");
    end
    txStart = 1'b1; dmaDisable = 1'b0; linkUp = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule